// File: doc/BRIEF.md
# Converter Power-Up Warmup Sequencer

This controller takes a mixed-signal converter out of shutdown and into conversion. When the supply is healthy and the external run pin is high, it starts the internal oscillator. It then turns on the analog front end. If the internal reference is in use, it turns that on too. Each of these steps is followed by a settling interval, counted in cycles of the internal oscillator. Last of all, the sequencer hands the clock to an external source if one is selected, and then enables both modulators. The analog blocks are outside this design. Each one is represented by the enable line that switches it.

The two configuration pins are captured at the moment the sequencer leaves shutdown, and they hold for the rest of that power-up. The reference choice decides whether the reference interval runs at all. The clock choice decides whether a one-cycle handover step is inserted before the modulators start. If the supply fails or the run pin falls, every enable drops in that same cycle, and the whole sequence starts again from the beginning on the next exit from shutdown.

Top module: `warmup_sequencer`

## Requirements
- R1: While `rst_n` is low, all six outputs are 0.
- R2: The sequence leaves shutdown only on a clock edge at which `supply_ok` and `run_req` are both 1. `osc_en` rises in the cycle after that edge.
- R3: `osc_en` is the only enable high for exactly `OSC_WAIT` cycles. `afe_en` rises after those cycles.
- R4: `afe_en` alone with `osc_en` lasts exactly `FE_WAIT` cycles, and `afe_en` then stays high until shutdown.
- R5: With `ref_ext_sel`=0 latched, `ref_en` rises after the front-end interval and stays high. The next step follows `REF_WAIT` cycles later.
- R6: With `ref_ext_sel`=1 latched, `ref_en` never rises, and the reference interval is skipped.
- R7: With `clk_ext_sel`=1 latched, once all intervals finish there is exactly one cycle with `osc_en`=0, `clk_switch`=1 and `mod_en`=0. After that cycle `mod_en` is 1, and `clk_switch` stays 1.
- R8: With `clk_ext_sel`=0 latched, `clk_switch` stays 0, `osc_en` stays 1, and `mod_en` rises in the cycle right after the last interval.
- R9: If `supply_ok` or `run_req` is 0, all outputs are 0 in that same cycle. The next start replays every interval from the oscillator step.
- R10: The configuration pins are sampled on each clock edge spent in shutdown. Changes made after the exit from shutdown have no effect until the next shutdown.
- R11: `active` is 1 exactly when `mod_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Sequencer clock, driven by the internal oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply is above the fail threshold |
| run_req | input | 1 | External run pin; low forces shutdown |
| ref_ext_sel | input | 1 | 1 = external reference, 0 = internal reference |
| clk_ext_sel | input | 1 | 1 = hand the clock to an external source at the end |
| osc_en | output | 1 | Internal oscillator enable |
| afe_en | output | 1 | Analog front-end enable |
| ref_en | output | 1 | Internal reference enable |
| clk_switch | output | 1 | Select the external clock source |
| mod_en | output | 1 | Enable both modulators |
| active | output | 1 | Status: conversion running |

## Verification
The bench builds the sequencer with `OSC_WAIT`=4, `FE_WAIT`=12 and `REF_WAIT`=20 instead of the full 16/8192/57344 cycles. With these values every interval boundary, the handover cycle and a run of steady conversion fit within a few dozen cycles per scenario. This makes it practical to run all four combinations of the two configuration pins, to abort partway through an interval, and to change the pins in the middle of a sequence. The same counter and decode logic is exercised as at the full lengths; only the load values are smaller.

// File: rtl/wu_pkg.sv
package wu_pkg;
  typedef enum logic [2:0] {
    ST_SHUT = 3'd0,
    ST_OSC  = 3'd1,
    ST_AFE  = 3'd2,
    ST_REF  = 3'd3,
    ST_HAND = 3'd4,
    ST_RUN  = 3'd5
  } wu_state_e;
endpackage

// File: rtl/wu_rst_sync.sv
module wu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wu_delay_cnt.sv
module wu_delay_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero); // R3
endmodule

// File: rtl/wu_fsm.sv
module wu_fsm
  import wu_pkg::*;
#(
  parameter int OSC_WAIT = 16,
  parameter int FE_WAIT  = 8192,
  parameter int REF_WAIT = 57344,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             cnt_zero,
  input  logic             ref_ext,
  input  logic             clk_ext,
  output wu_state_e        state,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val
);
  localparam logic [CNT_W-1:0] OSC_LD = CNT_W'(OSC_WAIT - 1);
  localparam logic [CNT_W-1:0] FE_LD  = CNT_W'(FE_WAIT - 1);
  localparam logic [CNT_W-1:0] REF_LD = CNT_W'(REF_WAIT - 1);

  wu_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = OSC_LD;
    if (!go) begin
      state_d = ST_SHUT;
    end else begin
      unique case (state_q)
        ST_SHUT: begin
          state_d  = ST_OSC;
          cnt_load = 1'b1;
          cnt_val  = OSC_LD;
        end
        ST_OSC: if (cnt_zero) begin
          state_d  = ST_AFE;
          cnt_load = 1'b1;
          cnt_val  = FE_LD;
        end
        ST_AFE: if (cnt_zero) begin
          if (!ref_ext) begin
            state_d  = ST_REF;
            cnt_load = 1'b1;
            cnt_val  = REF_LD;
          end else begin
            state_d  = clk_ext ? ST_HAND : ST_RUN;
          end
        end
        ST_REF:  if (cnt_zero) state_d = clk_ext ? ST_HAND : ST_RUN;
        ST_HAND: state_d = ST_RUN;
        ST_RUN:  state_d = ST_RUN;
        default: state_d = ST_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SHUT;
    else        state_q <= state_d;
  end

  assign state = state_q;

  AST_SHUT_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (state_q == ST_SHUT)); // R9
  AST_START_AT_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_SHUT) && ($past(state_q) == ST_SHUT)) |-> (state_q == ST_OSC)); // R2
endmodule

// File: rtl/wu_cfg_hold.sv
module wu_cfg_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic ref_ext_i,
  input  logic clk_ext_i,
  output logic ref_ext_o,
  output logic clk_ext_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_ext_o <= 1'b0;
      clk_ext_o <= 1'b0;
    end else if (capture) begin
      ref_ext_o <= ref_ext_i;
      clk_ext_o <= clk_ext_i;
    end
  end
endmodule

// File: rtl/warmup_sequencer.sv
module warmup_sequencer
  import wu_pkg::*;
#(
  parameter int OSC_WAIT = 16,
  parameter int FE_WAIT  = 8192,
  parameter int REF_WAIT = 57344
) (
  input  logic clk_osc,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic run_req,
  input  logic ref_ext_sel,
  input  logic clk_ext_sel,
  output logic osc_en,
  output logic afe_en,
  output logic ref_en,
  output logic clk_switch,
  output logic mod_en,
  output logic active
);
  localparam int MAX_A = (OSC_WAIT > FE_WAIT) ? OSC_WAIT : FE_WAIT;
  localparam int MAX_W = (MAX_A > REF_WAIT) ? MAX_A : REF_WAIT;
  localparam int CNT_W = $clog2(MAX_W + 1);

  logic             rst_i_n;
  logic             go;
  logic             cnt_load, cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  logic             ref_ext_q, clk_ext_q;
  wu_state_e        state;
  logic             past_afe, past_ref, at_end;

  assign go = supply_ok & run_req;

  wu_rst_sync u_rst (
    .clk        (clk_osc),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  wu_cfg_hold u_cfg (
    .clk       (clk_osc),
    .rst_n     (rst_i_n),
    .capture   (state == ST_SHUT),
    .ref_ext_i (ref_ext_sel),
    .clk_ext_i (clk_ext_sel),
    .ref_ext_o (ref_ext_q),
    .clk_ext_o (clk_ext_q)
  );

  wu_delay_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk_osc),
    .rst_n    (rst_i_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  wu_fsm #(
    .OSC_WAIT (OSC_WAIT),
    .FE_WAIT  (FE_WAIT),
    .REF_WAIT (REF_WAIT),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk      (clk_osc),
    .rst_n    (rst_i_n),
    .go       (go),
    .cnt_zero (cnt_zero),
    .ref_ext  (ref_ext_q),
    .clk_ext  (clk_ext_q),
    .state    (state),
    .cnt_load (cnt_load),
    .cnt_val  (cnt_val)
  );

  always_comb begin
    at_end   = (state == ST_HAND) || (state == ST_RUN);
    past_ref = (state == ST_REF) || at_end;
    past_afe = (state == ST_AFE) || past_ref;
    osc_en     = go && (state != ST_SHUT) && !(clk_ext_q && at_end);
    afe_en     = go && past_afe;
    ref_en     = go && !ref_ext_q && past_ref;
    clk_switch = go && clk_ext_q && at_end;
    mod_en     = go && (state == ST_RUN);
    active     = mod_en;
  end

  AST_CFG_FROZEN: assert property (@(posedge clk_osc) disable iff (!rst_i_n)
    ((state != ST_SHUT) && ($past(state) != ST_SHUT)) |-> ($stable(ref_ext_q) && $stable(clk_ext_q))); // R10
  AST_SWITCH_OSC_OFF: assert property (@(posedge clk_osc) disable iff (!rst_i_n)
    clk_switch |-> !osc_en); // R7
  AST_REF_INT_ONLY: assert property (@(posedge clk_osc) disable iff (!rst_i_n)
    ref_en |-> !ref_ext_q); // R6
  AST_MOD_AFTER_AFE: assert property (@(posedge clk_osc) disable iff (!rst_i_n)
    mod_en |-> (afe_en && $past(afe_en))); // R4
endmodule

// File: tb/warmup_sequencer_test.sv
module warmup_sequencer_test;
  localparam int OW = 4;
  localparam int FW = 12;
  localparam int RW = 20;

  logic clk = 1'b0;
  logic rst_n, supply_ok, run_req, ref_ext_sel, clk_ext_sel;
  logic osc_en, afe_en, ref_en, clk_switch, mod_en, active;

  int checks = 0;
  int failures = 0;
  int t = 0;
  bit m_ref_ext = 0;
  bit m_clk_ext = 0;
  bit chk_on = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  warmup_sequencer #(.OSC_WAIT(OW), .FE_WAIT(FW), .REF_WAIT(RW)) uut (
    .clk_osc(clk), .rst_n(rst_n), .supply_ok(supply_ok), .run_req(run_req),
    .ref_ext_sel(ref_ext_sel), .clk_ext_sel(clk_ext_sel),
    .osc_en(osc_en), .afe_en(afe_en), .ref_en(ref_en),
    .clk_switch(clk_switch), .mod_en(mod_en), .active(active)
  );

  // Behavioural model: elapsed edges since leaving shutdown.
  always @(posedge clk) begin
    if (!rst_n || !(supply_ok && run_req)) begin
      if (rst_n && t == 0) begin
        m_ref_ext = ref_ext_sel;
        m_clk_ext = clk_ext_sel;
      end
      t = 0;
    end else begin
      if (t == 0) begin
        m_ref_ext = ref_ext_sel;
        m_clk_ext = clk_ext_sel;
      end
      if (t < 100000) t = t + 1;
    end
  end

  function automatic logic [5:0] expect_out();
    int e;
    logic o, a, r, s, m;
    e = OW + FW + (m_ref_ext ? 0 : RW);
    o = 0; a = 0; r = 0; s = 0; m = 0;
    if (rst_n && supply_ok && run_req && t > 0) begin
      o = 1;
      if (t > OW) a = 1;
      if (!m_ref_ext && t > OW + FW) r = 1;
      if (t > e) begin
        if (m_clk_ext) begin
          o = 0; s = 1;
          m = (t > e + 1);
        end else begin
          m = 1;
        end
      end
    end
    return {o, a, r, s, m, m};
  endfunction

  always @(negedge clk) begin
    if (chk_on) begin
      logic [5:0] act, exp_v;
      act = {osc_en, afe_en, ref_en, clk_switch, mod_en, active};
      exp_v = expect_out();
      checks++;
      if (act !== exp_v) begin
        failures++;
        $display("FAIL %s t=%0d actual=%b expected=%b", tag, t, act, exp_v);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; supply_ok = 1; run_req = 1; ref_ext_sel = 0; clk_ext_sel = 0;
    // R1: outputs stay low while reset is held, even with go high
    step(3);
    checks++;
    if ({osc_en, afe_en, ref_en, clk_switch, mod_en, active} !== 6'b0) begin
      failures++;
      $display("FAIL R1 actual=%b expected=000000",
               {osc_en, afe_en, ref_en, clk_switch, mod_en, active});
    end
    supply_ok = 0; run_req = 0;
    step(1);
    rst_n = 1;
    step(4);
    chk_on = 1;
    // R2: only one of the two start conditions present
    tag = "R2";
    supply_ok = 1; run_req = 0; step(8);
    supply_ok = 0; run_req = 1; step(8);
    // R3 R4 R5 R8 R11: internal reference, internal clock
    tag = "R5/R8/R11";
    ref_ext_sel = 0; clk_ext_sel = 0; supply_ok = 1;
    step(OW + FW + RW + 10);
    // R9: shutdown drops everything; R6 R7 next with external ref and clock
    tag = "R9";
    run_req = 0; step(3);
    tag = "R6/R7";
    ref_ext_sel = 1; clk_ext_sel = 1; run_req = 1;
    step(OW + FW + 10);
    // R10: internal ref with external clock, pins changed mid-sequence
    tag = "R9";
    supply_ok = 0; step(2);
    tag = "R10";
    ref_ext_sel = 0; clk_ext_sel = 1; supply_ok = 1;
    step(OW + 2);
    ref_ext_sel = 1; clk_ext_sel = 0;
    step(FW + RW + 8);
    // R9: abort in the middle of the front-end interval, then full rerun (R3 R4)
    tag = "R9";
    run_req = 0; step(2);
    ref_ext_sel = 1; clk_ext_sel = 0; run_req = 1;
    step(OW + 5);
    supply_ok = 0; step(1);
    supply_ok = 1;
    tag = "R3/R4/R6/R8";
    step(OW + FW + 8);
    chk_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule